// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This engine takes received frames from a byte stream and stores each one in a buffer described by an entry in a ring of receive descriptors kept in system memory. Every descriptor is four 32-bit words (a 16-byte stride from the ring base). When a frame starts, the engine reads the current descriptor and checks three things: that hardware owns it, how large the buffer is, and whether the buffer address is acceptable. It then writes the frame bytes into the buffer one byte lane at a time. At the end it writes the status word back: the stored length, an error field, the address-class flags and both segment markers, with ownership returned to software. The ring position then advances, or goes back to the base when the descriptor carries the end-of-ring mark.

Address filtering and CRC checking happen upstream. The upstream logic reports its verdict on the last beat of the frame as a 5-bit error code and broadcast/multicast flags, and the engine merges these into the status word. A frame that meets a software-owned descriptor is still drained from the stream but is not stored, and an event output reports the missing buffer. Descriptor reads use a read port with one cycle of latency. All writes use a 32-bit write port with byte strobes.

Top module: `rx_ring_wb`

## Requirements
- R1: While reset is asserted and in the idle state afterwards, rx_ready, mem_rd_en, mem_wr_en, evt_rx_done and evt_no_buf are all 0.
- R2: When a frame's first beat is offered in idle, the engine reads descriptor words 0, 1 and 2 at addresses D, D+4 and D+8 on three consecutive cycles. D is ring_base plus 16 times the current ring index, and the index is 0 after reset.
- R3: If bit 31 (owner) of word 0 is 0, the whole frame is accepted and discarded. No memory write of any kind takes place, evt_no_buf pulses for one cycle together with the accepted last beat, and the ring index does not move.
- R4: A buffer address (word 2) is valid only if its bits 1:0 equal 2'b10. For any other value the frame is drained without byte writes, and the status word is written with length 0 and error bit 3 set.
- R5: Frame byte n is written to byte address B+n (B is the buffer address). mem_wr_addr is that address with bits 1:0 cleared, mem_wr_be is one-hot at lane (B+n)[1:0], and the byte is replicated on all four data lanes.
- R6: The status writeback is a single full-word write (mem_wr_be = 4'hF) to address D. Its fields are: stored length in bits 10:0, multicast in bit 16, broadcast in bit 17, error code in bits 22:18, last-segment in bit 28 = 1, first-segment in bit 29 = 1, and owner in bit 31 = 0. All other bits are 0.
- R7: Only the first S bytes are stored, where S is the buffer size in word 1 bits 10:0. When a frame is longer than S, the written length is S and error bit 4 is set. A frame of exactly S bytes is not flagged.
- R8: The error field written back is the OR of rx_err with the engine's own bits 4 and 3. rx_err, rx_bcast and rx_mcast are taken from the last beat.
- R9: After each status writeback the ring index goes up by one. If bit 31 of word 1 was set, it returns to 0 instead.
- R10: evt_rx_done pulses during the status-writeback cycle exactly when the error field written is 0.
- R11: rx_ready is 0 during idle and during the three fetch cycles. It is 1 from the cycle after the fetch until the last beat of the frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| rx_valid | input | 1 | Frame byte valid |
| rx_ready | output | 1 | Engine accepts the offered byte |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 5 | Upstream error code, valid with rx_last |
| rx_bcast | input | 1 | Broadcast frame, valid with rx_last |
| rx_mcast | input | 1 | Multicast frame, valid with rx_last |
| mem_rd_en | output | 1 | Descriptor read request |
| mem_rd_addr | output | AW | Descriptor read byte address |
| mem_rd_data | input | 32 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Memory write |
| mem_wr_addr | output | AW | Word-aligned write address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Byte strobes |
| evt_rx_done | output | 1 | Error-free frame stored |
| evt_no_buf | output | 1 | Frame dropped, descriptor owned by software |

## Verification
Frames are sent through a four-entry ring. The cases are: a clean frame; frames that overflow the buffer or fit it exactly; frames that carry upstream errors and class flags; buffers with a zero-offset address and with an odd address; and a descriptor owned by software. Overflow and exact fit are compared to show that the truncation flag fires only on a real overflow. Upstream errors combined with truncation or misalignment show that the error bits are merged, not overwritten. The software-owned case is followed by a frame that must use the same descriptor, which shows the index did not move. Two passes over the end-of-ring descriptor show the wrap back to the base.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W = 11;
  localparam int ERR_W = 5;

  // status word 0 field positions (decoded by software)
  localparam int W0_LEN_LO = 0;
  localparam int W0_MC     = 16;
  localparam int W0_BC     = 17;
  localparam int W0_ERR_LO = 18;
  localparam int W0_LS     = 28;
  localparam int W0_FS     = 29;
  localparam int W0_OWN    = 31;
  // control word 1
  localparam int W1_END    = 31;

  // error bits raised by the engine itself
  localparam int ERR_TRUNC = 4;
  localparam int ERR_ALIGN = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_F1,
    ST_F2,
    ST_F3,
    ST_DATA,
    ST_SKIP,
    ST_WB
  } rxr_state_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW     = 32,
  parameter int IDX_W  = 8,
  parameter int STR_LG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] desc_addr
);
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (advance) begin
      if (wrap) idx_d = '0;
      else      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_d;
  end

  assign desc_addr = base + (AW'(idx_q) << STR_LG);

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap) |=> (idx_q == '0));
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
endmodule

// File: rtl/rxr_byte_lane.sv
module rxr_byte_lane #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [AW-1:0]   byte_addr,
  input  logic [7:0]      byte_val,
  output logic [AW-1:0]   word_addr,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0]   data
);
  localparam int LANES = DW / 8;
  localparam int LG    = $clog2(LANES);

  assign word_addr = {byte_addr[AW-1:LG], {LG{1'b0}}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be[l]          = (byte_addr[LG-1:0] == LG'(l));
    assign data[8*l +: 8] = byte_val;
  end
endmodule

// File: rtl/rxr_wb_pack.sv
module rxr_wb_pack
  import rxr_pkg::*;
(
  input  logic [LEN_W-1:0] len,
  input  logic [ERR_W-1:0] err,
  input  logic             bcast,
  input  logic             mcast,
  output logic [31:0]      word
);
  always_comb begin
    word                                 = '0;
    word[W0_LEN_LO +: LEN_W]             = len;
    word[W0_MC]                          = mcast;
    word[W0_BC]                          = bcast;
    word[W0_ERR_LO +: ERR_W]             = err;
    word[W0_LS]                          = 1'b1;
    word[W0_FS]                          = 1'b1;
    word[W0_OWN]                         = 1'b0;
  end
endmodule

// File: rtl/rx_ring_wb.sv
module rx_ring_wb
  import rxr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic [4:0]    rx_err,
  input  logic          rx_bcast,
  input  logic          rx_mcast,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic [3:0]    mem_wr_be,
  output logic          evt_rx_done,
  output logic          evt_no_buf
);
  localparam int DW     = 32;
  localparam int BE_W   = DW / 8;
  localparam int STR_LG = $clog2(4 * BE_W);

  rxr_state_e       st_q, st_d;
  logic             own_q, own_d;
  logic [LEN_W-1:0] bsz_q, bsz_d;
  logic             end_q, end_d;
  logic [AW-1:0]    buf_q, buf_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             trunc_q, trunc_d;
  logic             bad_q, bad_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             bc_q, bc_d;
  logic             mc_q, mc_d;

  logic             advance;
  logic [AW-1:0]    desc_addr;
  logic [AW-1:0]    byte_addr;
  logic [AW-1:0]    ln_addr;
  logic [BE_W-1:0]  ln_be;
  logic [DW-1:0]    ln_data;
  logic [LEN_W-1:0] wb_len;
  logic [ERR_W-1:0] wb_err;
  logic [DW-1:0]    wb_word;
  logic             fits;

  rxr_ring_ptr #(.AW(AW), .IDX_W(IDX_W), .STR_LG(STR_LG)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (ring_base),
    .advance   (advance),
    .wrap      (end_q),
    .desc_addr (desc_addr)
  );

  assign byte_addr = buf_q + AW'(cnt_q);

  rxr_byte_lane #(.AW(AW), .DW(DW)) u_lane (
    .byte_addr (byte_addr),
    .byte_val  (rx_data),
    .word_addr (ln_addr),
    .be        (ln_be),
    .data      (ln_data)
  );

  assign wb_len = bad_q ? '0 : cnt_q;
  always_comb begin
    wb_err            = err_q;
    wb_err[ERR_TRUNC] = err_q[ERR_TRUNC] | trunc_q;
    wb_err[ERR_ALIGN] = err_q[ERR_ALIGN] | bad_q;
  end

  rxr_wb_pack u_pack (
    .len   (wb_len),
    .err   (wb_err),
    .bcast (bc_q),
    .mcast (mc_q),
    .word  (wb_word)
  );

  assign fits = (cnt_q < bsz_q);

  // next-state logic
  always_comb begin
    st_d        = st_q;
    own_d       = own_q;
    bsz_d       = bsz_q;
    end_d       = end_q;
    buf_d       = buf_q;
    cnt_d       = cnt_q;
    trunc_d     = trunc_q;
    bad_d       = bad_q;
    err_d       = err_q;
    bc_d        = bc_q;
    mc_d        = mc_q;
    rx_ready    = 1'b0;
    mem_rd_en   = 1'b0;
    mem_rd_addr = desc_addr;
    mem_wr_en   = 1'b0;
    mem_wr_addr = ln_addr;
    mem_wr_data = ln_data;
    mem_wr_be   = ln_be;
    advance     = 1'b0;
    evt_rx_done = 1'b0;
    evt_no_buf  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rx_valid) begin
          mem_rd_en = 1'b1;
          st_d      = ST_F1;
        end
      end
      ST_F1: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = desc_addr + AW'(4);
        own_d       = mem_rd_data[W0_OWN];
        st_d        = ST_F2;
      end
      ST_F2: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = desc_addr + AW'(8);
        bsz_d       = mem_rd_data[LEN_W-1:0];
        end_d       = mem_rd_data[W1_END];
        st_d        = ST_F3;
      end
      ST_F3: begin
        buf_d   = mem_rd_data[AW-1:0];
        bad_d   = (mem_rd_data[1:0] != 2'b10);
        cnt_d   = '0;
        trunc_d = 1'b0;
        st_d    = (own_q && (mem_rd_data[1:0] == 2'b10)) ? ST_DATA : ST_SKIP;
      end
      ST_DATA: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          if (fits) begin
            mem_wr_en = 1'b1;
            cnt_d     = cnt_q + LEN_W'(1);
          end else begin
            trunc_d = 1'b1;
          end
          if (rx_last) begin
            err_d = rx_err;
            bc_d  = rx_bcast;
            mc_d  = rx_mcast;
            st_d  = ST_WB;
          end
        end
      end
      ST_SKIP: begin
        rx_ready = 1'b1;
        if (rx_valid && rx_last) begin
          err_d      = rx_err;
          bc_d       = rx_bcast;
          mc_d       = rx_mcast;
          evt_no_buf = !own_q;
          st_d       = own_q ? ST_WB : ST_IDLE;
        end
      end
      ST_WB: begin
        mem_wr_en   = 1'b1;
        mem_wr_addr = desc_addr;
        mem_wr_data = wb_word;
        mem_wr_be   = '1;
        advance     = 1'b1;
        evt_rx_done = (wb_err == '0);
        st_d        = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      own_q   <= 1'b0;
      bsz_q   <= '0;
      end_q   <= 1'b0;
      buf_q   <= '0;
      cnt_q   <= '0;
      trunc_q <= 1'b0;
      bad_q   <= 1'b0;
      err_q   <= '0;
      bc_q    <= 1'b0;
      mc_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      own_q   <= own_d;
      bsz_q   <= bsz_d;
      end_q   <= end_d;
      buf_q   <= buf_d;
      cnt_q   <= cnt_d;
      trunc_q <= trunc_d;
      bad_q   <= bad_d;
      err_q   <= err_d;
      bc_q    <= bc_d;
      mc_q    <= mc_d;
    end
  end

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_F1) |-> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + AW'(4)));
  p_nobuf_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_no_buf |-> (!mem_wr_en && !evt_rx_done));
  p_lane_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_wr_be != 4'hF) |-> ($countones(mem_wr_be) == 1 && mem_wr_addr[1:0] == 2'b00));
  p_wb_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_wr_be == 4'hF) |-> (!mem_wr_data[W0_OWN] && mem_wr_data[W0_FS] && mem_wr_data[W0_LS]));
  p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_wr_be != 4'hF) |-> (cnt_q < bsz_q && !bad_q));
  p_done_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_done |-> (mem_wr_en && mem_wr_data[W0_ERR_LO +: ERR_W] == '0));
endmodule

// File: tb/rx_ring_wb_test.sv
module rx_ring_wb_test;
  localparam int AW = 32;
  localparam logic [31:0] RING = 32'h40;

  logic          clk, rst_n;
  logic          rx_valid, rx_ready, rx_last, rx_bcast, rx_mcast;
  logic [7:0]    rx_data;
  logic [4:0]    rx_err;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [31:0]   mem_rd_data, mem_wr_data;
  logic [3:0]    mem_wr_be;
  logic          evt_rx_done, evt_no_buf;

  rx_ring_wb #(.AW(AW), .IDX_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .ring_base(RING),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .rx_bcast(rx_bcast), .rx_mcast(rx_mcast),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_be(mem_wr_be), .evt_rx_done(evt_rx_done), .evt_no_buf(evt_no_buf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory model with a host write channel
  logic [31:0] mem [256];
  logic        hw_en;
  logic [31:0] hw_addr, hw_data;

  int wcnt, bcnt, ndone, nnobuf, rd_n, cyc;
  logic [31:0] rd_log [4];
  int          rd_cyc [4];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];
    if (hw_en) mem[hw_addr[9:2]] <= hw_data;
    if (mem_wr_en) begin
      for (int l = 0; l < 4; l++)
        if (mem_wr_be[l]) mem[mem_wr_addr[9:2]][8*l +: 8] <= mem_wr_data[8*l +: 8];
      if (mem_wr_be == 4'hF) wcnt <= wcnt + 1;
      else                   bcnt <= bcnt + 1;
    end
    if (evt_rx_done) ndone <= ndone + 1;
    if (evt_no_buf)  nnobuf <= nnobuf + 1;
    if (mem_rd_en && rd_n < 4) begin
      rd_log[rd_n] <= mem_rd_addr;
      rd_cyc[rd_n] <= cyc;
      rd_n <= rd_n + 1;
    end
  end

  int n_run, n_fail;
  bit done_flag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'(8'h40 + v * 16 + i);
  endfunction

  int first_wait;

  task automatic send_frame(input int v, input int len, input logic [4:0] e,
                            input logic b, input logic m);
    for (int i = 0; i < len; i++) begin
      int w;
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(v, i); rx_last = (i == len - 1);
      rx_err = (i == len - 1) ? e : 5'h1F;
      rx_bcast = (i == len - 1) ? b : 1'b1;
      rx_mcast = (i == len - 1) ? m : 1'b1;
      w = 0;
      while (!rx_ready) begin @(negedge clk); w++; end
      if (i == 0) first_wait = w;
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  typedef struct packed {
    logic [10:0] len;
    logic [10:0] bsz;
    logic [1:0]  aoff;
    logic [4:0]  err;
    logic        bc;
    logic        mc;
    logic        own;
    logic [10:0] xlen;
    logic [4:0]  xerr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{11'd10, 11'd64, 2'd2, 5'h00, 1'b0, 1'b0, 1'b1, 11'd10, 5'h00},
    '{11'd6,  11'd4,  2'd2, 5'h00, 1'b0, 1'b0, 1'b1, 11'd4,  5'h10},
    '{11'd8,  11'd64, 2'd2, 5'h03, 1'b1, 1'b0, 1'b1, 11'd8,  5'h03},
    '{11'd5,  11'd64, 2'd0, 5'h00, 1'b0, 1'b1, 1'b1, 11'd0,  5'h08},
    '{11'd7,  11'd64, 2'd2, 5'h00, 1'b0, 1'b0, 1'b0, 11'd0,  5'h00},
    '{11'd1,  11'd64, 2'd2, 5'h00, 1'b1, 1'b1, 1'b1, 11'd1,  5'h00},
    '{11'd4,  11'd4,  2'd2, 5'h00, 1'b0, 1'b0, 1'b1, 11'd4,  5'h00},
    '{11'd3,  11'd64, 2'd1, 5'h04, 1'b0, 1'b0, 1'b1, 11'd0,  5'h0C},
    '{11'd9,  11'd8,  2'd2, 5'h01, 1'b0, 1'b0, 1'b1, 11'd8,  5'h11}
  };

  initial begin
    #(20 * 100000);
    if (!done_flag) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int idx;
    string tg;
    n_run = 0; n_fail = 0; done_flag = 0;
    wcnt = 0; bcnt = 0; ndone = 0; nnobuf = 0; rd_n = 0; cyc = 0;
    hw_en = 0; hw_addr = 0; hw_data = 0;
    rx_valid = 0; rx_data = 0; rx_last = 0; rx_err = 0; rx_bcast = 0; rx_mcast = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rx_ready && !mem_rd_en && !mem_wr_en && !evt_rx_done && !evt_no_buf,
        "R1", "outputs in reset", {27'd0, rx_ready, mem_rd_en, mem_wr_en, evt_rx_done, evt_no_buf}, 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!rx_ready && !mem_rd_en && !mem_wr_en && !evt_rx_done && !evt_no_buf,
        "R1", "outputs idle after reset", {27'd0, rx_ready, mem_rd_en, mem_wr_en, evt_rx_done, evt_no_buf}, 32'h0);

    idx = 0;
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [31:0] daddr, bbase, baddr, w0_old, w0_exp;
      int b0, w0c, d0, n0;
      t = VECS[v];
      daddr = RING + 32'(idx) * 16;
      bbase = 32'h200 + 32'(idx) * 32'h40;
      baddr = bbase + 32'(t.aoff);
      for (int k = 0; k < 16; k++) host_wr(bbase + 32'(k) * 4, 32'hEEEE_EEEE);
      w0_old = {t.own, 31'h0000_07FF};
      host_wr(daddr,      w0_old);
      host_wr(daddr + 4,  {(idx == 3), 20'd0, t.bsz});
      host_wr(daddr + 8,  baddr);
      host_wr(daddr + 12, 32'h0);
      @(negedge clk);
      b0 = bcnt; w0c = wcnt; d0 = ndone; n0 = nnobuf; rd_n = 0;
      send_frame(v, int'(t.len), t.err, t.bc, t.mc);
      repeat (4) @(negedge clk);

      // R2 R9: descriptor fetch addresses and timing
      chk(rd_n == 3 && rd_log[0] == daddr && rd_log[1] == daddr + 4 && rd_log[2] == daddr + 8,
          "R2 R9", $sformatf("vec%0d fetch addresses", v), rd_log[0], daddr);
      chk(rd_cyc[1] == rd_cyc[0] + 1 && rd_cyc[2] == rd_cyc[0] + 2,
          "R2", $sformatf("vec%0d fetch consecutive", v), 32'(rd_cyc[2] - rd_cyc[0]), 32'd2);
      // R11: ready held low through idle and fetch
      chk(first_wait == 4, "R11", $sformatf("vec%0d first-beat wait", v), 32'(first_wait), 32'd4);
      chk(!rx_ready, "R11", $sformatf("vec%0d ready low after frame", v), {31'd0, rx_ready}, 32'd0);

      if (t.own) begin
        if (t.aoff != 2'd2)  tg = "R4";
        else if (t.xerr[4])  tg = "R7";
        else if (t.err != 0 || t.bc || t.mc) tg = "R8";
        else tg = "R6";
        w0_exp = {1'b0, 1'b0, 1'b1, 1'b1, 5'd0, t.xerr, t.bc, t.mc, 5'd0, t.xlen};
        chk(mem[daddr[9:2]] == w0_exp, tg, $sformatf("vec%0d status word", v), mem[daddr[9:2]], w0_exp);
        chk(wcnt - w0c == 1, "R6", $sformatf("vec%0d one full-word write", v), 32'(wcnt - w0c), 32'd1);
        chk(bcnt - b0 == int'(t.xlen), (t.aoff != 2'd2) ? "R4" : "R5",
            $sformatf("vec%0d byte write count", v), 32'(bcnt - b0), 32'(t.xlen));
        for (int i = 0; i < int'(t.xlen); i++)
          chk(mbyte(baddr + 32'(i)) == pat(v, i), "R5", $sformatf("vec%0d byte %0d", v, i),
              {24'd0, mbyte(baddr + 32'(i))}, {24'd0, pat(v, i)});
        chk(mbyte(baddr + 32'(t.xlen)) == 8'hEE, "R7", $sformatf("vec%0d byte past end", v),
            {24'd0, mbyte(baddr + 32'(t.xlen))}, 32'hEE);
        chk(ndone - d0 == ((t.xerr == 0) ? 1 : 0), "R10", $sformatf("vec%0d done event", v),
            32'(ndone - d0), (t.xerr == 0) ? 32'd1 : 32'd0);
        chk(nnobuf == n0, "R3", $sformatf("vec%0d no spurious nobuf", v), 32'(nnobuf - n0), 32'd0);
        idx = (idx == 3) ? 0 : idx + 1;
      end else begin
        chk(nnobuf - n0 == 1, "R3", "nobuf event", 32'(nnobuf - n0), 32'd1);
        chk(wcnt == w0c && bcnt == b0, "R3", "no writes when software-owned",
            32'((wcnt - w0c) + (bcnt - b0)), 32'd0);
        chk(mem[daddr[9:2]] == w0_old, "R3", "descriptor untouched", mem[daddr[9:2]], w0_old);
        chk(ndone == d0, "R10", "no done event on drop", 32'(ndone - d0), 32'd0);
      end
    end

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule